// File: doc/BRIEF.md
# Gated Sixteen-Bit Event Timer

This block is a 16-bit up-counter with a small byte-wide register interface. Each count step comes from one of two sources, picked by a control bit. The first is a single-cycle tick strobe that is already synchronous to the block clock. The second is an asynchronous clock pin, which is synchronized and edge-detected inside the block. Selected events pass through a prescaler that divides by 1, 2, 4 or 8 before they reach the counter.

An optional gate pin qualifies counting, with a programmable active level. This lets the counter measure how long an external condition holds, rather than only how much time has elapsed. When the counter wraps from all ones to zero, a sticky overflow flag sets and drives the interrupt output. The flag stays set until software clears it.

Software programs the block through four byte registers: count low, count high, control and status. It reads any of them through a combinational read port.

Top module: `gated_timer`

## Requirements
- R1: After reset the count is 0x0000, the control byte reads 0x00, the overflow flag is 0 and `irq` is low.
- R2: Register select 0 reads and writes count bits 7:0, select 1 reads and writes count bits 15:8, and select 2 reads and writes the control byte. Control byte bit 0 is run, bit 1 picks the external source, bits 3:2 are the prescale code, bit 4 enables gating, bit 5 is the gate polarity (1 = active high), and bits 7:6 read 0. Select 3 is status, with the overflow flag in bit 0 and the other bits reading 0.
- R3: With run=1, internal source, prescale code 0 and gating off, each clock cycle with `tick_in` high adds one to the count at that clock edge.
- R4: Prescale codes 0, 1, 2 and 3 make the count advance once per 1, 2, 4 and 8 qualified source events.
- R5: With the external source selected, the count advances once for each rising edge of `ext_clk`, on the third clock edge after the pin rises. Holding the pin high adds nothing further, and `tick_in` is ignored.
- R6: With run=0, source events do not change the count.
- R7: With gating enabled, events are counted only while the two-flop-synchronized `gate_in` equals the polarity bit.
- R8: With gating disabled, the level of `gate_in` has no effect on counting.
- R9: An increment from 0xFFFF gives 0x0000 and sets the overflow flag, which drives `irq`.
- R10: The overflow flag stays set until status is written with bit 0 = 1. Writing status with bit 0 = 0 leaves it set. A wrap in the same cycle as a clearing write leaves the flag set.
- R11: Writing either count byte clears the prescaler phase. A count-byte write in the same cycle as an increment stores the written byte and discards the increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select for writes |
| wr_data | input | 8 | Write data byte |
| rd_sel | input | 2 | Register select for reads |
| rd_data | output | 8 | Combinational read data |
| tick_in | input | 1 | Synchronous internal tick strobe |
| ext_clk | input | 1 | Asynchronous external count clock |
| gate_in | input | 1 | Asynchronous count gate pin |
| irq | output | 1 | Overflow interrupt (sticky flag) |

## Verification
Two pairs of functions can land in the same clock cycle. In the first pair, the counter wraps while software writes the status register to clear the flag. The bench loads 0xFFFF, then raises `tick_in` in the same cycle as a clearing status write, and expects the flag to survive. In the second pair, an increment meets a count-byte write. The bench pulses `tick_in` together with a low-byte write and expects exactly the written value, with no added step.

// File: rtl/gtmr_pkg.sv
package gtmr_pkg;

    localparam int BYTE_W   = 8;
    localparam int CNT_W    = 16;
    localparam int PS_W     = 2;
    localparam int PS_CNT_W = (1 << PS_W) - 1;
    localparam int SYNC_N   = 2;

    typedef enum logic [1:0] {
        SEL_CNT_LO = 2'd0,
        SEL_CNT_HI = 2'd1,
        SEL_CTRL   = 2'd2,
        SEL_STAT   = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [1:0]      spare;
        logic            gate_pol;
        logic            gate_en;
        logic [PS_W-1:0] psel;
        logic            clk_ext;
        logic            run;
    } ctrl_t;

    typedef struct packed {
        logic wr_lo;
        logic wr_hi;
        logic wr_ctrl;
        logic wr_stat;
    } wr_dec_t;

    function automatic logic [PS_CNT_W-1:0] presc_term(input logic [PS_W-1:0] sel);
        logic [PS_CNT_W-1:0] t;
        t = '0;
        for (int i = 0; i < PS_CNT_W; i++) begin
            if (i < int'(sel)) t[i] = 1'b1;
        end
        return t;
    endfunction

    function automatic wr_dec_t decode_wr(input logic en, input logic [1:0] sel);
        wr_dec_t d;
        d.wr_lo   = en && (reg_sel_e'(sel) == SEL_CNT_LO);
        d.wr_hi   = en && (reg_sel_e'(sel) == SEL_CNT_HI);
        d.wr_ctrl = en && (reg_sel_e'(sel) == SEL_CTRL);
        d.wr_stat = en && (reg_sel_e'(sel) == SEL_STAT);
        return d;
    endfunction

endpackage

// File: rtl/gtmr_sync.sv
module gtmr_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stg[0] <= '0;
        else     stg[0] <= d;
    end

    generate
        for (genvar i = 1; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) stg[i] <= '0;
                else     stg[i] <= stg[i-1];
            end
        end
    endgenerate

    assign q = stg[STAGES-1];
endmodule

// File: rtl/gtmr_source.sv
module gtmr_source
    import gtmr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  ctrl_t ctrl,
    input  logic  tick_in,
    input  logic  ext_s,
    input  logic  gate_s,
    output logic  event_q
);
    logic ext_prev;
    logic ext_rise;
    logic gate_ok;
    logic raw_evt;

    always_ff @(posedge clk) begin
        if (rst) ext_prev <= 1'b0;
        else     ext_prev <= ext_s;
    end

    assign ext_rise = ext_s && !ext_prev;
    assign raw_evt  = ctrl.clk_ext ? ext_rise : tick_in;
    assign gate_ok  = !ctrl.gate_en || (gate_s == ctrl.gate_pol);
    assign event_q  = ctrl.run && gate_ok && raw_evt;
endmodule

// File: rtl/gtmr_prescale.sv
module gtmr_prescale
    import gtmr_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            clr,
    input  logic [PS_W-1:0] sel,
    input  logic            evt,
    output logic            step
);
    logic [PS_CNT_W-1:0] phase;
    logic [PS_CNT_W-1:0] term;
    logic                at_term;

    assign term    = presc_term(sel);
    assign at_term = (phase >= term);
    assign step    = evt && at_term && !clr;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            phase <= '0;
        end else if (evt) begin
            if (at_term) phase <= '0;
            else         phase <= phase + 1'b1;
        end
    end
endmodule

// File: rtl/gtmr_counter.sv
module gtmr_counter
    import gtmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              step,
    output logic [CNT_W-1:0]  count,
    output logic              wrap
);
    localparam logic [CNT_W-1:0] ALL_ONES = '1;

    assign wrap = step && !wr_lo && !wr_hi && (count == ALL_ONES);

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (wr_lo || wr_hi) begin
            if (wr_lo) count[BYTE_W-1:0]       <= wdata;
            if (wr_hi) count[CNT_W-1:BYTE_W]   <= wdata;
        end else if (step) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/gated_timer.sv
module gated_timer
    import gtmr_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [1:0]  wr_sel,
    input  logic [7:0]  wr_data,
    input  logic [1:0]  rd_sel,
    output logic [7:0]  rd_data,
    input  logic        tick_in,
    input  logic        ext_clk,
    input  logic        gate_in,
    output logic        irq
);
    ctrl_t            ctrl_q;
    wr_dec_t          wd;
    logic [1:0]       pin_s;
    logic             evt;
    logic             step;
    logic             wrap;
    logic             ovf_q;
    logic [CNT_W-1:0] count;

    assign wd = decode_wr(wr_en, wr_sel);

    gtmr_sync #(.W(2), .STAGES(SYNC_N)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({gate_in, ext_clk}),
        .q   (pin_s)
    );

    gtmr_source u_src (
        .clk     (clk),
        .rst     (rst),
        .ctrl    (ctrl_q),
        .tick_in (tick_in),
        .ext_s   (pin_s[0]),
        .gate_s  (pin_s[1]),
        .event_q (evt)
    );

    gtmr_prescale u_ps (
        .clk  (clk),
        .rst  (rst),
        .clr  (wd.wr_lo || wd.wr_hi),
        .sel  (ctrl_q.psel),
        .evt  (evt),
        .step (step)
    );

    gtmr_counter u_cnt (
        .clk   (clk),
        .rst   (rst),
        .wr_lo (wd.wr_lo),
        .wr_hi (wd.wr_hi),
        .wdata (wr_data),
        .step  (step),
        .count (count),
        .wrap  (wrap)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (wd.wr_ctrl) begin
            ctrl_q       <= ctrl_t'(wr_data);
            ctrl_q.spare <= '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                          ovf_q <= 1'b0;
        else if (wrap)                    ovf_q <= 1'b1;
        else if (wd.wr_stat && wr_data[0]) ovf_q <= 1'b0;
    end

    assign irq = ovf_q;

    always_comb begin
        unique case (reg_sel_e'(rd_sel))
            SEL_CNT_LO: rd_data = count[BYTE_W-1:0];
            SEL_CNT_HI: rd_data = count[CNT_W-1:BYTE_W];
            SEL_CTRL:   rd_data = ctrl_q;
            SEL_STAT:   rd_data = {7'd0, ovf_q};
            default:    rd_data = '0;
        endcase
    end
endmodule

// File: rtl/gated_timer_chk.sv
module gated_timer_chk (
    input logic        clk,
    input logic        rst,
    input logic        wr_en,
    input logic [1:0]  wr_sel,
    input logic [7:0]  wr_data,
    input logic        run,
    input logic        step,
    input logic [15:0] count,
    input logic        irq
);
    logic wr_cnt;
    assign wr_cnt = wr_en && (wr_sel == 2'd0 || wr_sel == 2'd1);

    // R6
    a_r6_halt_when_off: assert property (@(posedge clk) disable iff (rst)
        (!run && !wr_cnt) |=> $stable(count));

    // R9
    a_r9_wrap_sets_flag: assert property (@(posedge clk) disable iff (rst)
        (step && !wr_cnt && count == 16'hFFFF) |=> (irq && count == 16'h0000));

    // R10
    a_r10_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        (irq && !(wr_en && wr_sel == 2'd3 && wr_data[0])) |=> irq);

    // R11
    a_r11_write_wins: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == 2'd0) |=> (count[7:0] == $past(wr_data)));

    // R4
    a_r4_single_step: assert property (@(posedge clk) disable iff (rst)
        !wr_cnt |=> (count == $past(count) || count == $past(count) + 16'd1));

    // R10
    a_r10_flag_needs_wrap: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(step && count == 16'hFFFF));
endmodule

bind gated_timer gated_timer_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .run     (ctrl_q.run),
    .step    (step),
    .count   (count),
    .irq     (irq)
);

// File: tb/gated_timer_bench.sv
module gated_timer_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic [1:0] rd_sel = 2'd0;
    logic [7:0] rd_data;
    logic       tick_in = 1'b0;
    logic       ext_clk = 1'b0;
    logic       gate_in = 1'b0;
    logic       irq;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    gated_timer u_gated_timer (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data), .tick_in(tick_in), .ext_clk(ext_clk),
        .gate_in(gate_in), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] sel, output logic [7:0] d);
        rd_sel = sel;
        #1;
        d = rd_data;
    endtask

    task automatic rd_count(output logic [15:0] c);
        logic [7:0] lo, hi;
        rd(2'd0, lo);
        rd(2'd1, hi);
        c = {hi, lo};
    endtask

    task automatic set_count(input logic [15:0] v);
        wr(2'd0, v[7:0]);
        wr(2'd1, v[15:8]);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_in = 1'b1;
            @(negedge clk); tick_in = 1'b0;
        end
    endtask

    task automatic t_reset();
        logic [7:0] d;
        for (int s = 0; s < 4; s++) begin
            rd(2'(s), d);
            check("R1 reset reg", d, 8'h00);
        end
        check("R1 irq", irq, 1'b0);
    endtask

    task automatic t_regs();
        logic [7:0] d;
        wr(2'd0, 8'hA5); wr(2'd1, 8'h3C); wr(2'd2, 8'hFE);
        rd(2'd0, d); check("R2 low", d, 8'hA5);
        rd(2'd1, d); check("R2 high", d, 8'h3C);
        rd(2'd2, d); check("R2 ctrl spare bits", d, 8'h3E);
        rd(2'd3, d); check("R2 status", d, 8'h00);
        wr(2'd2, 8'h00);
    endtask

    task automatic t_internal();
        logic [15:0] c;
        set_count(16'h0000);
        wr(2'd2, 8'h01);
        ticks(5);
        rd_count(c); check("R3 five ticks", c, 16'd5);
    endtask

    task automatic t_prescale();
        logic [15:0] c;
        for (int p = 1; p < 4; p++) begin
            set_count(16'h0000);
            wr(2'd2, 8'(8'h01 | (p << 2)));
            ticks(3 * (1 << p) + (1 << p) - 1);
            rd_count(c); check("R4 prescale divide", c, 16'd3);
        end
    endtask

    task automatic t_run_off();
        logic [15:0] c;
        set_count(16'h0010);
        wr(2'd2, 8'h00);
        ticks(4);
        rd_count(c); check("R6 halted", c, 16'h0010);
    endtask

    task automatic t_external();
        logic [15:0] c;
        set_count(16'h0000);
        wr(2'd2, 8'h03);
        @(negedge clk); ext_clk = 1'b1;
        @(negedge clk); @(negedge clk);
        rd_count(c); check("R5 not yet", c, 16'd0);
        @(negedge clk);
        rd_count(c); check("R5 third edge", c, 16'd1);
        repeat (5) @(negedge clk);
        ticks(3);
        rd_count(c); check("R5 held high, ticks ignored", c, 16'd1);
        ext_clk = 1'b0;
        repeat (3) @(negedge clk);
        ext_clk = 1'b1;
        repeat (4) @(negedge clk);
        rd_count(c); check("R5 second edge", c, 16'd2);
        ext_clk = 1'b0;
    endtask

    task automatic t_gate();
        logic [15:0] c;
        set_count(16'h0000);
        gate_in = 1'b0;
        wr(2'd2, 8'h31);
        repeat (3) @(negedge clk);
        ticks(3);
        rd_count(c); check("R7 gate low blocks (active high)", c, 16'd0);
        gate_in = 1'b1;
        repeat (3) @(negedge clk);
        ticks(3);
        rd_count(c); check("R7 gate high counts", c, 16'd3);
        wr(2'd2, 8'h11);
        ticks(2);
        rd_count(c); check("R7 active-low blocks", c, 16'd3);
        gate_in = 1'b0;
        repeat (3) @(negedge clk);
        ticks(2);
        rd_count(c); check("R7 active-low counts", c, 16'd5);
        wr(2'd2, 8'h21);
        ticks(4);
        rd_count(c); check("R8 gate ignored when disabled", c, 16'd9);
    endtask

    task automatic t_overflow();
        logic [15:0] c;
        logic [7:0]  d;
        wr(2'd2, 8'h01);
        set_count(16'hFFFF);
        check("R9 no flag before wrap", irq, 1'b0);
        ticks(1);
        rd_count(c); check("R9 wrapped count", c, 16'h0000);
        check("R9 irq", irq, 1'b1);
        rd(2'd3, d); check("R9 status bit", d, 8'h01);
        ticks(10);
        wr(2'd3, 8'h00);
        check("R10 zero write keeps flag", irq, 1'b1);
        wr(2'd3, 8'h01);
        check("R10 one write clears", irq, 1'b0);
        set_count(16'hFFFF);
        @(negedge clk);
        tick_in = 1'b1; wr_en = 1'b1; wr_sel = 2'd3; wr_data = 8'h01;
        @(negedge clk);
        tick_in = 1'b0; wr_en = 1'b0;
        check("R10 wrap beats clear", irq, 1'b1);
        wr(2'd3, 8'h01);
    endtask

    task automatic t_write_presc();
        logic [15:0] c;
        set_count(16'h0000);
        wr(2'd2, 8'h0D);
        ticks(5);
        wr(2'd0, 8'h00);
        ticks(7);
        rd_count(c); check("R11 prescaler restarted", c, 16'd0);
        ticks(1);
        rd_count(c); check("R11 eighth event steps", c, 16'd1);
        wr(2'd2, 8'h01);
        set_count(16'h0000);
        @(negedge clk);
        tick_in = 1'b1; wr_en = 1'b1; wr_sel = 2'd0; wr_data = 8'h40;
        @(negedge clk);
        tick_in = 1'b0; wr_en = 1'b0;
        rd_count(c); check("R11 write beats increment", c, 16'h0040);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_regs();
        t_internal();
        t_prescale();
        t_run_off();
        t_external();
        t_gate();
        t_overflow();
        t_write_presc();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule